// File: doc/BRIEF.md
# Page-Aligned Write Staging Buffer

This block gathers the data bytes of one write transaction into a staging buffer. The buffer covers exactly one physical page of the array, and its contents reach the array only once the transaction closes with a Stop. A transaction opens with a start pulse that carries the first word address. The upper address bits pick the page. The lower bits pick the slot for the first byte. Each byte that follows goes into the next slot of the same page, and the slot index wraps from the last slot back to slot 0 instead of crossing into the next page. If more bytes arrive than the page holds, each new byte replaces the oldest one, so the buffer ends up holding the most recent page-worth.

Incoming bytes use a valid/ready stream. The buffer takes a byte only while `in_ready` is high, which is the case only while a transaction is open and no start, stop or abort pulse is present in the same cycle. The commit side is also a valid/ready stream toward the array. Each entry stays on the port until the array accepts it, so the array may stall it for any number of cycles. When the write-inhibit input is high at the Stop, the buffered bytes are dropped and the busy period still runs. An abort, such as a repeated Start, drops the buffered bytes and starts no busy period. `busy` covers the commit drain and the timed write cycle that follows it.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy`, `wr_valid` and `in_ready` are all 0.
- R2: A byte received first after a start with address A is committed at address A, and the commit data equals the received byte. A byte write is a transaction with a single byte and produces exactly one commit.
- R3: Each received byte advances only the low log2(PAGE_BYTES) address bits, modulo PAGE_BYTES. The page bits of every commit equal those of the start address. With 16-byte pages, starting at 0x3E and sending 4 bytes gives the addresses 0x3E, 0x3F, 0x30 and 0x31.
- R4: If more than PAGE_BYTES bytes are received, each slot holds the latest byte written to it, and exactly PAGE_BYTES commits follow the Stop.
- R5: Only slots that received a byte are committed, one commit per slot. No commit appears before the Stop.
- R6: Commits come out in ascending slot order. While `wr_valid` is 1 and `wr_ready` is 0, `wr_addr` and `wr_data` hold their values and `wr_valid` stays 1.
- R7: A Stop with `wr_inhibit` at 1 produces no commit, and `busy` is then high for exactly BUSY_CYCLES cycles.
- R8: An abort drops the buffered bytes. No commit follows, `busy` stays 0 and `in_ready` returns to 0.
- R9: After a Stop with N buffered bytes, commit allowed and `wr_ready` held at 1, `busy` is high for N + BUSY_CYCLES cycles. While `busy` is 1, `in_ready` is 0 and a start pulse is ignored.
- R10: A Stop with no bytes buffered produces no commit and no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Opens a transaction (pulse) |
| start_addr | input | ADDR_W | Word address of the first byte |
| in_valid | input | 1 | Incoming byte valid |
| in_ready | output | 1 | Buffer accepts a byte this cycle |
| in_data | input | DATA_W | Incoming byte |
| stop_i | input | 1 | Transaction ended by a Stop (pulse) |
| abort_i | input | 1 | Transaction ended without a Stop (pulse) |
| wr_inhibit | input | 1 | Write protect decision, sampled at the Stop |
| wr_valid | output | 1 | Commit entry valid |
| wr_ready | input | 1 | Array accepts the commit entry |
| wr_addr | output | ADDR_W | Commit address |
| wr_data | output | DATA_W | Commit data |
| busy | output | 1 | Commit drain or timed write cycle in progress |

## Verification
A wrong slot index or a lost page latch shows up on the very first commit after the Stop, because `wr_addr` then differs from the address the bench predicts. A valid mask that is stale or never cleared shows up as extra or missing commits in the same drain, which the bench finds when the expected queue is left with entries or runs empty. A timer or state error changes the number of `busy` cycles, which is checked against N + BUSY_CYCLES at the end of every transaction. Protect and abort faults show up as commits the bench did not expect.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_HOLD  = 2'd3
  } pwb_state_e;
endpackage

// File: rtl/pwb_slots.sv
// Page-sized byte store with a per-slot valid mask.
module pwb_slots #(
  parameter int SLOTS  = 16,
  parameter int DATA_W = 8,
  localparam int IW    = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              put_en,
  input  logic [IW-1:0]     put_idx,
  input  logic [DATA_W-1:0] put_data,
  input  logic              retire_en,
  input  logic [IW-1:0]     retire_idx,
  input  logic [IW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [SLOTS-1:0]  mask
);
  logic [DATA_W-1:0] mem_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
        mask[g]  <= 1'b0;
      end else if (clr) begin
        mask[g] <= 1'b0;
      end else if (put_en && put_idx == IW'(g)) begin
        mem_q[g] <= put_data;
        mask[g]  <= 1'b1;
      end else if (retire_en && retire_idx == IW'(g)) begin
        mask[g] <= 1'b0;
      end
    end
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/pwb_pick.sv
// Lowest-index set bit finder.
module pwb_pick #(
  parameter int SLOTS = 16,
  localparam int IW   = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] mask,
  output logic [IW-1:0]    idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end
  assign any = |mask;
endmodule

// File: rtl/pwb_timer.sv
// Counts a fixed write cycle while enabled; done on the last cycle.
module pwb_timer #(
  parameter int CYCLES = 16,
  localparam int CW    = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en)    cnt_q <= '0;
    else if (!done)  cnt_q <= cnt_q + 1'b1;
  end

  assign done = en && (cnt_q == CW'(CYCLES - 1));
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
  import pwb_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 16,
  localparam int OFS_W      = $clog2(PAGE_BYTES),
  localparam int PAGE_W     = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              stop_i,
  input  logic              abort_i,
  input  logic              wr_inhibit,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy
);
  pwb_state_e state_q, state_d;
  logic [PAGE_W-1:0]     page_q;
  logic [OFS_W-1:0]      ofs_q;
  logic [PAGE_BYTES-1:0] mask, rest;
  logic [OFS_W-1:0]      pick_idx;
  logic                  pick_any, timer_done;
  logic                  in_fill, start_take, accept, retire, clr;

  assign in_fill    = (state_q == ST_FILL);
  assign start_take = start_valid &&
                      ((state_q == ST_IDLE) || (in_fill && !abort_i && !stop_i));
  assign in_ready   = in_fill && !abort_i && !stop_i && !start_valid;
  assign accept     = in_valid && in_ready;
  assign wr_valid   = (state_q == ST_DRAIN) && pick_any;
  assign retire     = wr_valid && wr_ready;
  assign clr        = start_take || (in_fill && abort_i) ||
                      (in_fill && stop_i && wr_inhibit);
  assign rest       = mask & ~(PAGE_BYTES'(1) << pick_idx);
  assign busy       = (state_q == ST_DRAIN) || (state_q == ST_HOLD);
  assign wr_addr    = {page_q, pick_idx};

  pwb_slots #(.SLOTS(PAGE_BYTES), .DATA_W(DATA_W)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .put_en    (accept),
    .put_idx   (ofs_q),
    .put_data  (in_data),
    .retire_en (retire),
    .retire_idx(pick_idx),
    .rd_idx    (pick_idx),
    .rd_data   (wr_data),
    .mask      (mask)
  );

  pwb_pick #(.SLOTS(PAGE_BYTES)) u_pick (
    .mask(mask),
    .idx (pick_idx),
    .any (pick_any)
  );

  pwb_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (state_q == ST_HOLD),
    .done (timer_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_take) state_d = ST_FILL;
      ST_FILL: begin
        if (abort_i)           state_d = ST_IDLE;
        else if (stop_i) begin
          if (!pick_any)       state_d = ST_IDLE;
          else if (wr_inhibit) state_d = ST_HOLD;
          else                 state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: if (retire && rest == '0) state_d = ST_HOLD;
      ST_HOLD:  if (timer_done)           state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      ofs_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start_take) begin
        page_q <= start_addr[ADDR_W-1:OFS_W];
        ofs_q  <= start_addr[OFS_W-1:0];
      end else if (accept) begin
        ofs_q  <= ofs_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              abort_i,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy
);
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && $past(wr_valid && wr_ready) |->
      wr_addr[OFS_W-1:0] > $past(wr_addr[OFS_W-1:0]));

  assert_same_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && $past(wr_valid) |->
      wr_addr[ADDR_W-1:OFS_W] == $past(wr_addr[ADDR_W-1:OFS_W]));

  assert_commit_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);

  assert_no_input_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i && !busy |=> !busy && !wr_valid);
endmodule

bind page_write_buffer pwb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_ready(in_ready),
  .abort_i (abort_i),
  .wr_valid(wr_valid),
  .wr_ready(wr_ready),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .busy    (busy)
);

// File: tb/page_write_buffer_tb.sv
`timescale 1ns/1ps
module page_write_buffer_tb;
  localparam int BUSYC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_valid = 1'b0;
  logic [7:0] start_addr = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       stop_i = 1'b0;
  logic       abort_i = 1'b0;
  logic       wr_inhibit = 1'b0;
  logic       wr_valid;
  logic       wr_ready = 1'b1;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       busy;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  logic [7:0]  m_data [16];
  logic [15:0] m_mask;
  logic [3:0]  m_page, m_ofs;
  logic        bp_en = 1'b0;

  always #2 clk = ~clk;

  page_write_buffer #(.BUSY_CYCLES(BUSYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .stop_i(stop_i), .abort_i(abort_i), .wr_inhibit(wr_inhibit),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // back-pressure pattern on the commit side
  int bp_cnt = 0;
  always @(negedge clk) begin
    bp_cnt <= bp_cnt + 1;
    wr_ready <= bp_en ? (bp_cnt % 3 != 1) : 1'b1;
  end

  // monitor: pops expected commits, checks stall stability
  logic       prev_stall = 1'b0;
  logic [7:0] prev_a, prev_d;
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (prev_stall)
          chk(wr_valid && wr_addr == prev_a && wr_data == prev_d, "R6 stall hold",
              {wr_addr, wr_data}, {prev_a, prev_d});
        if (wr_valid && wr_ready) begin
          if (exp_q.size() == 0) chk(1'b0, "R5 unexpected commit", {wr_addr, wr_data}, 0);
          else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk({wr_addr, wr_data} == e, "R2 R3 R4 R6 commit", {wr_addr, wr_data}, e);
          end
        end
        prev_stall = wr_valid && !wr_ready;
        prev_a = wr_addr; prev_d = wr_data;
      end
    end
  end

  task automatic begin_txn(input logic [7:0] a);
    @(negedge clk);
    start_valid = 1'b1; start_addr = a;
    @(negedge clk);
    start_valid = 1'b0;
    m_page = a[7:4]; m_ofs = a[3:0]; m_mask = '0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    in_valid = 1'b1; in_data = d;
    #1;
    chk(in_ready == 1'b1, "R9 ready in fill", in_ready, 1);
    chk(wr_valid == 1'b0, "R5 no early commit", wr_valid, 0);
    @(negedge clk);
    in_valid = 1'b0;
    m_data[m_ofs] = d; m_mask[m_ofs] = 1'b1; m_ofs = m_ofs + 1'b1;
  endtask

  // ends with Stop; returns busy cycle count
  task automatic end_stop(input logic inh, output int bcnt);
    stop_i = 1'b1; wr_inhibit = inh;
    if (!inh)
      for (int s = 0; s < 16; s++)
        if (m_mask[s]) exp_q.push_back({m_page, 4'(s), m_data[s]});
    @(negedge clk);
    stop_i = 1'b0; wr_inhibit = 1'b0;
    #1;
    bcnt = 0;
    while (busy && bcnt < 1000) begin
      bcnt++;
      @(negedge clk); #1;
    end
    chk(exp_q.size() == 0, "R5 all commits seen", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
  endtask

  initial begin
    int b;
    fork
      begin
        repeat (3) @(negedge clk);
        #1;
        chk(busy == 0 && wr_valid == 0 && in_ready == 0, "R1 reset outputs",
            {busy, wr_valid, in_ready}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // byte write
        begin_txn(8'h25); send_byte(8'hA5); end_stop(1'b0, b);
        chk(b == 1 + BUSYC, "R9 busy length byte", b, 1 + BUSYC);

        // wrap within page
        begin_txn(8'h3E);
        for (int i = 0; i < 4; i++) send_byte(8'h10 + 8'(i));
        end_stop(1'b0, b);
        chk(b == 4 + BUSYC, "R3 busy length wrap", b, 4 + BUSYC);

        // overrun keeps latest 16
        begin_txn(8'h73);
        for (int i = 0; i < 20; i++) send_byte(8'h40 + 8'(i));
        chk(m_mask == 16'hFFFF, "R4 model full", m_mask, 16'hFFFF);
        end_stop(1'b0, b);
        chk(b == 16 + BUSYC, "R4 sixteen commits", b, 16 + BUSYC);

        // partial page, only received slots
        begin_txn(8'h80);
        for (int i = 0; i < 3; i++) send_byte(8'hC0 + 8'(i));
        end_stop(1'b0, b);
        chk(b == 3 + BUSYC, "R5 partial count", b, 3 + BUSYC);

        // back-pressure on commit stream
        bp_en = 1'b1;
        begin_txn(8'hC5);
        for (int i = 0; i < 6; i++) send_byte(8'h90 + 8'(i));
        end_stop(1'b0, b);
        chk(b > 6 + BUSYC, "R6 stalls lengthen drain", b, 7 + BUSYC);
        bp_en = 1'b0;
        repeat (2) @(negedge clk);

        // inhibited write
        begin_txn(8'h12);
        for (int i = 0; i < 5; i++) send_byte(8'h55);
        end_stop(1'b1, b);
        chk(b == BUSYC, "R7 inhibit busy length", b, BUSYC);

        // abort
        begin_txn(8'h44);
        for (int i = 0; i < 3; i++) send_byte(8'h66);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0; #1;
        chk(busy == 0 && in_ready == 0, "R8 abort quiet", {busy, in_ready}, 0);
        m_mask = '0;
        end_stop(1'b0, b);
        chk(b == 0, "R8 no busy after abort", b, 0);

        // empty stop
        begin_txn(8'h50);
        end_stop(1'b0, b);
        chk(b == 0, "R10 empty stop", b, 0);

        // start ignored while busy
        begin_txn(8'h60); send_byte(8'h77);
        stop_i = 1'b1; exp_q.push_back({8'h60, 8'h77});
        @(negedge clk);
        stop_i = 1'b0;
        start_valid = 1'b1; start_addr = 8'h90; in_valid = 1'b1; in_data = 8'hEE;
        #1;
        chk(busy == 1 && in_ready == 0, "R9 not ready while busy", {busy, in_ready}, 2'b10);
        @(negedge clk);
        start_valid = 1'b0; in_valid = 1'b0;
        while (busy) @(negedge clk);
        #1;
        chk(in_ready == 0, "R9 start ignored while busy", in_ready, 0);
        chk(exp_q.size() == 0, "R9 commit after busy start", exp_q.size(), 0);
        repeat (3) @(negedge clk);
        #1;
        chk(wr_valid == 0 && busy == 0, "R9 nothing from ignored start",
            {wr_valid, busy}, 0);
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule